// File: doc/BRIEF.md
# Dual 8-bit Timer with Shared Compare/Capture Register

The block holds two 8-bit timer channels, numbered 0 (even) and 1 (odd). Each channel has an up counter that advances on its own tick input and a constant register that serves one of two roles. In compare mode, the channel watches for the counter to reach the register value. On that match it raises the channel's flag and updates its timer output pin as set by a 2-bit output-select field. In capture mode, the channel instead watches its capture input. A chosen edge on that input loads the current counter value into the same register and raises the same flag.

Software reaches the block through a small bus. Each channel has a status byte and a constant register. A 16-bit access covers both channels at once, with channel 0 in the upper byte. When the odd channel is capturing, the even channel's compare matches are suppressed. A standby input holds both constant registers at all ones.

Top module: `tcc_pair`

## Requirements
- R1: After reset, both constant registers read 0xFF, both status bytes read 0x00, and both timer outputs are low.
- R2: A byte access reads or writes one register. Address 0 is status 0, address 1 is status 1, address 2 is constant 0 and address 3 is constant 1. Read data appears in bits 7:0 and bits 15:8 are zero.
- R3: A word access with bus_word=1 reaches both channels. Address bit 1 picks status (0) or constant (1). Channel 0 is in bits 15:8 and channel 1 is in bits 7:0.
- R4: While standby is high, both constant registers are held at 0xFF and bus writes to them are lost.
- R5: Each tick adds one to the channel counter, and the counter wraps from 0xFF to 0x00. In compare mode, the flag (status bit 7) is set in the same clock in which the updated counter equals the constant register.
- R6: On a compare match, status bits 3:2 set the output: 00 leaves it unchanged, 01 drives it low, 10 drives it high, 11 toggles it. The output changes at no other time.
- R7: Writing 0 to the flag clears it only if a read has returned the flag as 1 since it was last cleared. Writing 1 to the flag has no effect. Status bits 6:2 take the written value.
- R8: If a set event and a flag clear fall in the same clock, the flag stays set.
- R9: Status bit 6 = 1 selects capture mode. Status bits 5:4 select the capture edge: 00 rising, 01 falling, 1x both. The input passes through two synchronizer stages. The register is loaded with the counter value three clocks after the input changes, the flag is set, and edges of the other polarity are ignored.
- R10: While channel 1 is in capture mode, a compare match on channel 0 sets no flag and leaves channel 0's output unchanged.
- R11: A channel in capture mode never sets its flag from a compare match with its own counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Holds both constant registers at all ones |
| tick | input | 2 | Per-channel counter advance pulse |
| cap_in | input | 2 | Per-channel capture input (asynchronous) |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access to both channels |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| tmr_out | output | 2 | Per-channel timer output pin |

## Verification
The capture assertion relates the register to the counter one clock earlier. It therefore assumes that the capture inputs are low when reset is released, so that the synchronizer does not report a false edge. The stimulus holds both capture inputs low through reset. It changes them only when no tick is pending, so every captured value is one the bench can predict. The inhibit property assumes that flags are raised only by hardware events, never by a bus write. The bench writes 1 to a flag only to show that such a write does nothing. The bench moves bus signals and ticks on the falling clock edge, and never overlaps a capture edge with a bus write to the same register.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    OSEL_KEEP   = 2'b00,
    OSEL_LOW    = 2'b01,
    OSEL_HIGH   = 2'b10,
    OSEL_TOGGLE = 2'b11
  } osel_e;

  // status byte layout: {flag, cap_en, edge_sel[1:0], osel[1:0], 2'b00}
  localparam int FLAG_BIT = 7;
  localparam int CAPM_BIT = 6;
  localparam int EDGE_LSB = 4;
  localparam int OSEL_LSB = 2;

  function automatic logic f_out_next(input logic cur, input logic [1:0] sel);
    case (osel_e'(sel))
      OSEL_LOW:    return 1'b0;
      OSEL_HIGH:   return 1'b1;
      OSEL_TOGGLE: return ~cur;
      default:     return cur;
    endcase
  endfunction

  function automatic logic f_edge_hit(input logic now, input logic prev,
                                      input logic [1:0] sel);
    logic rise, fall;
    rise = now & ~prev;
    fall = ~now & prev;
    if (sel[1])      return rise | fall;
    else if (sel[0]) return fall;
    else             return rise;
  endfunction

  function automatic logic f_flag_next(input logic cur, input logic set_ev,
                                       input logic clr_ev);
    if (set_ev)      return 1'b1;
    else if (clr_ev) return 1'b0;
    else             return cur;
  endfunction

endpackage

// File: rtl/tcc_sync_edge.sv
module tcc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit
);
  import tcc_pkg::*;

  logic [STAGES-1:0] sr;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sr[STAGES-1];

  assign hit = f_edge_hit(sr[STAGES-1], prev, sel);
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] nxt
);
  assign nxt = tick ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          tick,
  input  logic          cap_in,
  input  logic          inhibit,
  input  logic          rb_we,
  input  logic          stat_we,
  input  logic          stat_re,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rb,
  output logic [DW-1:0] stat_byte,
  output logic [DW-1:0] cnt,
  output logic          tmr_out,
  output logic          flag,
  output logic          cap_mode,
  output logic          cmp_hit,
  output logic          cap_hit
);
  import tcc_pkg::*;

  logic [DW-1:0] nxt;
  logic [1:0]    edge_sel, osel;
  logic          armed, edge_hit, set_ev, clr_ev;

  tcc_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .nxt(nxt)
  );

  tcc_sync_edge #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .sel(edge_sel), .hit(edge_hit)
  );

  assign cap_hit = cap_mode & edge_hit;
  assign cmp_hit = tick & (nxt == rb) & ~cap_mode & ~inhibit;
  assign set_ev  = cmp_hit | cap_hit;
  assign clr_ev  = stat_we & ~wdata[FLAG_BIT] & armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag     <= 1'b0;
      armed    <= 1'b0;
      cap_mode <= 1'b0;
      edge_sel <= 2'b00;
      osel     <= 2'b00;
    end else begin
      flag <= f_flag_next(flag, set_ev, clr_ev);
      if (clr_ev && !set_ev)   armed <= 1'b0;
      else if (stat_re && flag) armed <= 1'b1;
      if (stat_we) begin
        cap_mode <= wdata[CAPM_BIT];
        edge_sel <= wdata[EDGE_LSB +: 2];
        osel     <= wdata[OSEL_LSB +: 2];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rb <= '1;
    else if (standby) rb <= '1;
    else if (cap_hit) rb <= cnt;
    else if (rb_we)   rb <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tmr_out <= 1'b0;
    else if (cmp_hit) tmr_out <= f_out_next(tmr_out, osel);

  assign stat_byte = {flag, cap_mode, edge_sel, osel, {(DW-6){1'b0}}};
endmodule

// File: rtl/tcc_pair.sv
module tcc_pair #(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic [1:0]    tick,
  input  logic [1:0]    cap_in,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic          bus_word,
  input  logic [1:0]    bus_addr,
  input  logic [2*DW-1:0] bus_wdata,
  output logic [2*DW-1:0] bus_rdata,
  output logic [1:0]    tmr_out
);
  localparam int NCH = 2;
  localparam int WW  = 2 * DW;

  logic [NCH-1:0][DW-1:0] rb_q, stat_q, cnt_q, rd_byte, ch_wdata;
  logic [NCH-1:0] flag_q, cap_mode, cmp_hit, cap_hit, inhibit;
  logic [NCH-1:0] ch_sel, rb_we, stat_we, stat_re;
  logic           reg_is_rb;

  assign reg_is_rb = bus_addr[1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_sel[i]   = bus_en & (bus_word | (bus_addr[0] == i[0]));
    assign rb_we[i]    = ch_sel[i] & bus_wr & reg_is_rb;
    assign stat_we[i]  = ch_sel[i] & bus_wr & ~reg_is_rb;
    assign stat_re[i]  = ch_sel[i] & ~bus_wr & ~reg_is_rb;
    assign ch_wdata[i] = (bus_word && i == 0) ? bus_wdata[WW-1:DW]
                                              : bus_wdata[DW-1:0];
    assign rd_byte[i]  = reg_is_rb ? rb_q[i] : stat_q[i];

    if (i % 2 == 0) begin : g_even
      assign inhibit[i] = cap_mode[i+1];
    end else begin : g_odd
      assign inhibit[i] = 1'b0;
    end

    tcc_channel #(.DW(DW), .STAGES(STAGES)) u_chan (
      .clk(clk), .rst_n(rst_n), .standby(standby), .tick(tick[i]),
      .cap_in(cap_in[i]), .inhibit(inhibit[i]), .rb_we(rb_we[i]),
      .stat_we(stat_we[i]), .stat_re(stat_re[i]), .wdata(ch_wdata[i]),
      .rb(rb_q[i]), .stat_byte(stat_q[i]), .cnt(cnt_q[i]),
      .tmr_out(tmr_out[i]), .flag(flag_q[i]), .cap_mode(cap_mode[i]),
      .cmp_hit(cmp_hit[i]), .cap_hit(cap_hit[i])
    );
  end

  always_comb begin
    if (bus_word) bus_rdata = {rd_byte[0], rd_byte[1]};
    else          bus_rdata = {{DW{1'b0}}, rd_byte[bus_addr[0]]};
  end
endmodule

// File: rtl/tcc_pair_chk.sv
module tcc_pair_chk #(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   standby,
  input logic [NCH-1:0]         tick,
  input logic [NCH-1:0][DW-1:0] cnt,
  input logic [NCH-1:0][DW-1:0] rb,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0]         cap_mode,
  input logic [NCH-1:0]         cmp_hit,
  input logic [NCH-1:0]         cap_hit,
  input logic [NCH-1:0]         tmr_out
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_standby_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> rb[i] == {DW{1'b1}});
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && cnt[i] == {DW{1'b1}}) |=> cnt[i] == '0);
    p_match_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[i] |=> flag[i]);
    p_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_hit[i] |=> $stable(tmr_out[i]));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_hit[i] |=> flag[i]);
    p_capture_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit[i] && !standby) |=> rb[i] == $past(cnt[i]));
  end

  p_even_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag[0] && cap_mode[1] && !cap_mode[0]) |=> !flag[0]);
endmodule

bind tcc_pair tcc_pair_chk #(.DW(DW), .NCH(2)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .tick(tick), .cnt(cnt_q),
  .rb(rb_q), .flag(flag_q), .cap_mode(cap_mode), .cmp_hit(cmp_hit),
  .cap_hit(cap_hit), .tmr_out(tmr_out)
);

// File: tb/tb_tcc_pair.sv
`timescale 1ns/1ps
module tb_tcc_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [1:0]  tick = 2'b00;
  logic [1:0]  cap_in = 2'b00;
  logic        bus_en = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [1:0]  bus_addr = 2'b00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic [1:0]  tmr_out;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tcc_pair dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .tick(tick), .cap_in(cap_in),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_out(tmr_out)
  );

  // {word, addr[1:0], wdata[15:0], expected read[15:0]}: write then read back
  localparam logic [34:0] VEC [0:5] = '{
    {1'b0, 2'd2, 16'h005A, 16'h005A},  // R2 constant 0
    {1'b0, 2'd3, 16'h00C3, 16'h00C3},  // R2 constant 1
    {1'b1, 2'd2, 16'h1234, 16'h1234},  // R3 word constants
    {1'b1, 2'd0, 16'h2C14, 16'h2C14},  // R3 word status
    {1'b1, 2'd0, 16'h0000, 16'h0000},  // R3 status back to zero
    {1'b0, 2'd0, 16'h0080, 16'h0000}   // R7 writing 1 to flag does nothing
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic w, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_word = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_word = 1'b0;
  endtask

  task automatic bread(input logic w, input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_word = w; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0; bus_word = 1'b0;
  endtask

  task automatic rcheck(input string req, input logic [1:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bread(1'b0, a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input int ch, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick[ch] = 1'b1;
      @(negedge clk); tick[ch] = 1'b0;
    end
  endtask

  task automatic set_pin(input int ch, input logic v);
    @(negedge clk); cap_in[ch] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rcheck("R1 const0", 2'd2, 16'h00FF);
    rcheck("R1 const1", 2'd3, 16'h00FF);
    bread(1'b1, 2'd0, d); check("R1 status word", d, 16'h0000);
    check("R1 outputs", {14'h0, tmr_out}, 16'h0000);

    for (int v = 0; v < 6; v++) begin
      bwrite(VEC[v][34], VEC[v][33:32], VEC[v][31:16]);
      bread(VEC[v][34], VEC[v][33:32], d);
      check($sformatf("R2/R3/R7 vector %0d", v), d, VEC[v][15:0]);
    end
    rcheck("R3 upper byte is channel 0", 2'd2, 16'h0012);
    rcheck("R3 lower byte is channel 1", 2'd3, 16'h0034);

    // R4 standby
    bwrite(1'b0, 2'd2, 16'h0010);
    @(negedge clk); standby = 1'b1;
    @(negedge clk);
    bwrite(1'b0, 2'd3, 16'h0022);
    bread(1'b1, 2'd2, d); check("R4 held at ones", d, 16'hFFFF);
    @(negedge clk); standby = 1'b0;
    rcheck("R4 write during standby lost", 2'd3, 16'h00FF);

    // R5/R6 compare on channel 0, drive high
    bwrite(1'b0, 2'd2, 16'h0003);
    bwrite(1'b0, 2'd0, 16'h0008);
    pulse(0, 2);
    check("R5 no early flag", {15'h0, tmr_out[0]}, 16'h0000);
    pulse(0, 1);
    check("R6 drive high", {15'h0, tmr_out[0]}, 16'h0001);
    rcheck("R5 flag on match", 2'd0, 16'h0088);
    bwrite(1'b0, 2'd0, 16'h000C);
    rcheck("R7 cleared after read", 2'd0, 16'h000C);

    // R5 wrap: 256 ticks back to 3, toggle output
    pulse(0, 256);
    check("R6 toggle after wrap", {15'h0, tmr_out[0]}, 16'h0000);
    bwrite(1'b0, 2'd0, 16'h000C);
    rcheck("R7 clear without read ignored", 2'd0, 16'h008C);

    // R8 set and clear in one cycle
    bwrite(1'b0, 2'd2, 16'h0004);
    @(negedge clk);
    tick[0] = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_word = 1'b0;
    bus_addr = 2'd0; bus_wdata = 16'h000C;
    @(negedge clk);
    tick[0] = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
    rcheck("R8 set wins", 2'd0, 16'h008C);
    check("R8 toggle", {15'h0, tmr_out[0]}, 16'h0001);

    // R6 keep and drive low
    bwrite(1'b0, 2'd0, 16'h0000);
    bwrite(1'b0, 2'd2, 16'h0005);
    pulse(0, 1);
    check("R6 keep", {15'h0, tmr_out[0]}, 16'h0001);
    rcheck("R6 keep still flags", 2'd0, 16'h0080);
    bwrite(1'b0, 2'd0, 16'h0004);
    bwrite(1'b0, 2'd2, 16'h0006);
    pulse(0, 1);
    check("R6 drive low", {15'h0, tmr_out[0]}, 16'h0000);
    rcheck("R6 low flags", 2'd0, 16'h0084);

    // R9 capture on channel 1
    bwrite(1'b0, 2'd1, 16'h0040);
    pulse(1, 7);
    set_pin(1, 1'b1);
    rcheck("R9 rising capture value", 2'd3, 16'h0007);
    rcheck("R9 rising capture flag", 2'd1, 16'h00C0);
    bwrite(1'b0, 2'd1, 16'h0040);
    pulse(1, 2);
    set_pin(1, 1'b0);
    rcheck("R9 falling ignored", 2'd3, 16'h0007);
    rcheck("R9 no flag on ignored edge", 2'd1, 16'h0040);
    bwrite(1'b0, 2'd1, 16'h0050);
    set_pin(1, 1'b1);
    rcheck("R9 rising ignored in falling mode", 2'd3, 16'h0007);
    pulse(1, 1);
    set_pin(1, 1'b0);
    rcheck("R9 falling capture", 2'd3, 16'h000A);
    rcheck("R9 falling flag", 2'd1, 16'h00D0);
    bwrite(1'b0, 2'd1, 16'h0060);
    pulse(1, 1);
    set_pin(1, 1'b1);
    rcheck("R9 both-edge capture", 2'd3, 16'h000B);
    rcheck("R9 both-edge flag", 2'd1, 16'h00E0);

    // R11 capture mode ignores own compare
    bwrite(1'b0, 2'd1, 16'h0060);
    bwrite(1'b0, 2'd3, 16'h000C);
    pulse(1, 1);
    rcheck("R11 no flag from own compare", 2'd1, 16'h0060);
    check("R11 output unchanged", {15'h0, tmr_out[1]}, 16'h0000);

    // R10 odd capture inhibits even compare
    bwrite(1'b0, 2'd0, 16'h000C);
    bwrite(1'b0, 2'd2, 16'h0007);
    pulse(0, 1);
    rcheck("R10 even flag suppressed", 2'd0, 16'h000C);
    check("R10 even output held", {15'h0, tmr_out[0]}, 16'h0000);
    bwrite(1'b0, 2'd1, 16'h0000);
    bwrite(1'b0, 2'd2, 16'h0008);
    pulse(0, 1);
    rcheck("R10 even flag after release", 2'd0, 16'h008C);
    check("R10 even output toggles", {15'h0, tmr_out[0]}, 16'h0001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule